// File: doc/BRIEF.md
# Tree Reduction Sum Engine

This block collapses one partial sum per lane into a single total. A bank of lane registers is filled either all at once from a wide parallel bus or one lane at a time through an indexed write port. A start pulse then launches the reduction. Each clock the engine halves an active count and adds the upper half of the active lanes into the lower half. The lane registers update together on one edge, so every round reads only values that are already settled. When the active count is odd, the element left without a partner is folded into lane 0 in the same round.

When the count reaches one, lane 0 holds the total. It is copied to the sum output, and a done flag pulses for one cycle. The write port uses a valid/ready handshake. A write moves only in a cycle where both `wr_valid` and `wr_ready` are high. `wr_ready` is low during a reduction and in any cycle where `start` is high, so a writer must hold its data and index stable until it sees ready. Control pins (`start`, `load_par`, `done`) are plain levels and pulses.

Top module: `tree_sum_engine`

## Requirements
- R1: After reset `sum_out` is 0, `done` is 0 and `wr_ready` is 1.
- R2: A start sampled while idle with `load_par` = 1 loads lane i from bits [i*WIDTH +: WIDTH] of `par_data`, and the run result is the sum of those LANES values.
- R3: While idle, a cycle with `wr_valid` and `wr_ready` both high stores `wr_data` into lane `wr_lane`, and an index of LANES or above stores nothing. A start with `load_par` = 0 reduces the lane contents as written and ignores `par_data`.
- R4: The active count starts at LANES. In each round, an odd count first folds lane count-1 into lane 0. The count then becomes count/2, rounded down, and every lane i below the new count adds lane i+count. With default parameters, a value placed in any single lane (including those folded at counts 25 and 3) reaches the total.
- R5: `done` rises exactly K+1 clock edges after the edge that samples start, where K is the number of halvings from LANES down to 1 (K = 6, so 7 edges, for 100 lanes).
- R6: `done` is high for exactly one cycle. `sum_out` changes only together with `done` and keeps its value until the next completion.
- R7: All additions wrap modulo 2^WIDTH, so 100 lanes of all-ones sum to 0xFFFFFF9C at the default width.
- R8: A start that arrives while a reduction is running is ignored. The result, its timing and the count of done pulses are unchanged.
- R9: `wr_ready` is low while a reduction runs and in any cycle where `start` is high. A write offered then does not reach any lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a reduction (honoured only when idle) |
| load_par | input | 1 | At start: 1 loads lanes from `par_data`, 0 keeps written contents |
| par_data | input | LANES*WIDTH | Parallel lane values, lane i in bits [i*WIDTH +: WIDTH] |
| wr_valid | input | 1 | Write offer on the lane port |
| wr_ready | output | 1 | Write port can accept this cycle |
| wr_lane | input | clog2(LANES) | Target lane of the write |
| wr_data | input | WIDTH | Value written to the lane |
| sum_out | output | WIDTH | Total of the last completed run |
| done | output | 1 | One-cycle pulse when `sum_out` takes a new total |

## Verification
Two cases are hardest to reach from the ports. One is a request that arrives in the middle of a run: a write offer held through the whole reduction, and a second start with different parallel data pulsed two cycles in. The bench builds both and checks that the first run's total and timing are untouched. The other is an element that is consumed only by the odd-count fold. It is exposed by placing a single non-zero value in lanes 99, 24 and 2, the lanes that only the fold at counts 25 and 3 (or the last pairing) pulls in, and checking that it reaches the total.

// File: rtl/tre_pkg.sv
package tre_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tre_state_e;

  // number of halvings needed to bring a count of n down to 1
  function automatic int tre_rounds(input int n);
    int c;
    int r;
    c = n;
    r = 0;
    while (c > 1) begin
      c = c / 2;
      r = r + 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/tre_ctrl.sv
module tre_ctrl
  import tre_pkg::*;
#(
  parameter int LANES = 100,
  parameter int CNTW  = $clog2(LANES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            accept,
  output logic            busy,
  output logic            round_en,
  output logic            finish,
  output logic [CNTW-1:0] cnt
);

  tre_state_e state_q;

  assign busy     = (state_q == ST_RUN);
  assign accept   = !busy && start;
  assign finish   = busy && (cnt == CNTW'(1));
  assign round_en = busy && (cnt != CNTW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt     <= CNTW'(LANES);
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            cnt     <= CNTW'(LANES);
          end
        end
        ST_RUN: begin
          if (cnt == CNTW'(1)) begin
            state_q <= ST_IDLE;
          end else begin
            cnt <= cnt >> 1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tre_lane.sv
module tre_lane #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_val,
  input  logic             round_en,
  input  logic [WIDTH-1:0] pair_val,
  input  logic [WIDTH-1:0] fold_val,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load_en) begin
      q <= load_val;
    end else if (wr_en) begin
      q <= wr_val;
    end else if (round_en) begin
      q <= q + pair_val + fold_val;
    end
  end

endmodule

// File: rtl/tree_sum_engine.sv
module tree_sum_engine
  import tre_pkg::*;
#(
  parameter  int LANES = 100,
  parameter  int WIDTH = 32,
  localparam int IDXW  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNTW  = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   load_par,
  input  logic [LANES*WIDTH-1:0] par_data,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [IDXW-1:0]        wr_lane,
  input  logic [WIDTH-1:0]       wr_data,
  output logic [WIDTH-1:0]       sum_out,
  output logic                   done
);

  logic            accept;
  logic            busy;
  logic            round_en;
  logic            finish;
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] half;
  logic [IDXW-1:0] fold_idx;
  logic [WIDTH-1:0] fold_v;
  logic [WIDTH-1:0] lane_q [LANES];
  logic [WIDTH-1:0] pair_v [LANES];
  logic             wr_fire;

  tre_ctrl #(.LANES(LANES), .CNTW(CNTW)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .accept   (accept),
    .busy     (busy),
    .round_en (round_en),
    .finish   (finish),
    .cnt      (cnt)
  );

  assign wr_ready = !busy && !start;
  assign wr_fire  = wr_valid && wr_ready;
  assign half     = cnt >> 1;
  assign fold_idx = IDXW'(cnt - CNTW'(1));
  assign fold_v   = (round_en && cnt[0]) ? lane_q[fold_idx] : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      pair_v[i] = '0;
      if (i < int'(half) && (i + int'(half)) < LANES) begin
        pair_v[i] = lane_q[IDXW'(i + int'(half))];
      end
    end

    tre_lane #(.WIDTH(WIDTH)) lane_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (accept && load_par),
      .load_val (par_data[i*WIDTH +: WIDTH]),
      .wr_en    (wr_fire && (wr_lane == IDXW'(i))),
      .wr_val   (wr_data),
      .round_en (round_en),
      .pair_val (pair_v[i]),
      .fold_val ((i == 0) ? fold_v : '0),
      .q        (lane_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      sum_out <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        sum_out <= lane_q[0];
      end
    end
  end

endmodule

// File: rtl/tree_sum_chk.sv
module tree_sum_chk
  import tre_pkg::*;
#(
  parameter int LANES = 100,
  parameter int WIDTH = 32,
  parameter int CNTW  = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             wr_ready,
  input logic             done,
  input logic [WIDTH-1:0] sum_out,
  input logic             busy,
  input logic [CNTW-1:0]  cnt
);

  localparam int RUN_LEN = tre_rounds(LANES) + 1;

  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= 0;
    end else if (!busy && start) begin
      busy_len <= 0;
    end else if (busy) begin
      busy_len <= busy_len + 1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_SUM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sum_out)); // R6
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || start) |-> !wr_ready); // R9
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && cnt == CNTW'(LANES))); // R4
  AST_COUNT_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CNTW'(1)) |=> (busy && cnt == ($past(cnt) >> 1))); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CNTW'(1) && start) |=> (cnt == ($past(cnt) >> 1))); // R8
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && busy_len == RUN_LEN)); // R5

endmodule

bind tree_sum_engine tree_sum_chk #(.LANES(LANES), .WIDTH(WIDTH), .CNTW(CNTW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .wr_ready (wr_ready),
  .done     (done),
  .sum_out  (sum_out),
  .busy     (busy),
  .cnt      (cnt)
);

// File: tb/tree_sum_engine_tb_top.sv
`timescale 1ns/1ps
module tree_sum_engine_tb_top;

  localparam int LANES = 100;
  localparam int WIDTH = 32;
  localparam int IDXW  = $clog2(LANES);

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start = 1'b0;
  logic                   load_par = 1'b0;
  logic [LANES*WIDTH-1:0] par_data = '0;
  logic                   wr_valid = 1'b0;
  logic                   wr_ready;
  logic [IDXW-1:0]        wr_lane = '0;
  logic [WIDTH-1:0]       wr_data = '0;
  logic [WIDTH-1:0]       sum_out;
  logic                   done;

  int n_chk = 0;
  int n_fail = 0;
  logic [WIDTH-1:0] vals [LANES];

  always #4 clk = ~clk;

  tree_sum_engine #(.LANES(LANES), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .load_par(load_par),
    .par_data(par_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_lane(wr_lane), .wr_data(wr_data), .sum_out(sum_out), .done(done)
  );

  function automatic int exp_latency();
    int c = LANES;
    int r = 0;
    while (c > 1) begin
      c = c / 2;
      r++;
    end
    return r + 1;
  endfunction

  function automatic logic [WIDTH-1:0] ref_sum();
    logic [WIDTH-1:0] s = '0;
    for (int i = 0; i < LANES; i++) s = s + vals[i];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pack_par();
    for (int i = 0; i < LANES; i++) par_data[i*WIDTH +: WIDTH] = vals[i];
  endtask

  // launch a run and wait for done; lat = edges from the start-sampling edge
  task automatic launch_wait(input bit par, output int lat);
    @(negedge clk);
    start = 1'b1;
    load_par = par;
    @(posedge clk);
    #1 start = 1'b0;
    lat = -1;
    for (int n = 1; n <= 64; n++) begin
      @(posedge clk);
      #2;
      if (done) begin
        lat = n;
        break;
      end
    end
  endtask

  task automatic t_reset();
    #2;
    check(sum_out == '0, "R1 sum_out after reset", longint'(sum_out), 0);
    check(done == 1'b0, "R1 done after reset", longint'(done), 0);
    check(wr_ready == 1'b1, "R1 wr_ready after reset", longint'(wr_ready), 1);
  endtask

  task automatic t_par(input string tag);
    int lat;
    logic [WIDTH-1:0] held;
    pack_par();
    launch_wait(1'b1, lat);
    check(sum_out == ref_sum(), {"R2 R4 parallel sum ", tag}, longint'(sum_out), longint'(ref_sum()));
    check(lat == exp_latency(), {"R5 latency ", tag}, lat, exp_latency());
    held = sum_out;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #2;
      check(!done && sum_out == held, {"R6 done pulse and hold ", tag}, longint'(sum_out), longint'(held));
    end
  endtask

  task automatic t_patterns();
    for (int i = 0; i < LANES; i++) vals[i] = WIDTH'(i * 3 + 1);
    t_par("ascending");
    for (int i = 0; i < LANES; i++) vals[i] = WIDTH'(i * i * 40503 + 17);
    t_par("scrambled");
  endtask

  task automatic t_single_lanes();
    int pick [6] = '{0, 2, 24, 49, 50, 99};
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < LANES; i++) vals[i] = '0;
      vals[pick[k]] = WIDTH'(32'h1234_0000 + pick[k]);
      t_par($sformatf("R4 lone lane %0d", pick[k]));
    end
  endtask

  task automatic t_wrap();
    int lat;
    for (int i = 0; i < LANES; i++) vals[i] = '1;
    pack_par();
    launch_wait(1'b1, lat);
    check(sum_out == 32'hFFFF_FF9C, "R7 wrap all ones", longint'(sum_out), 32'hFFFF_FF9C);
  endtask

  task automatic t_port();
    int lat;
    for (int i = 0; i < LANES; i++) begin
      @(negedge clk);
      check(wr_ready == 1'b1, "R3 ready while idle", longint'(wr_ready), 1);
      wr_valid = 1'b1;
      wr_lane = IDXW'(i);
      wr_data = WIDTH'(1000 + i);
      @(posedge clk);
      #1 wr_valid = 1'b0;
    end
    // out-of-range index must be dropped
    @(negedge clk);
    wr_valid = 1'b1;
    wr_lane = IDXW'(LANES + 5);
    wr_data = 32'h7777_7777;
    @(posedge clk);
    #1 wr_valid = 1'b0;
    par_data = {LANES{32'hDEAD_BEEF}};
    launch_wait(1'b0, lat);
    check(sum_out == 32'd104950, "R3 port loaded sum", longint'(sum_out), 104950);
  endtask

  task automatic t_start_busy();
    int lat;
    int extra_done;
    for (int i = 0; i < LANES; i++) vals[i] = WIDTH'(7 * i + 2);
    pack_par();
    @(negedge clk);
    start = 1'b1;
    load_par = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = -1;
    for (int n = 1; n <= 64; n++) begin
      if (n == 3) begin
        par_data = {LANES{32'h0000_0005}};
        start = 1'b1;
      end
      @(posedge clk);
      #1 start = 1'b0;
      #1;
      if (done) begin
        lat = n;
        break;
      end
    end
    check(sum_out == ref_sum(), "R8 start while busy ignored (sum)", longint'(sum_out), longint'(ref_sum()));
    check(lat == exp_latency(), "R8 start while busy ignored (latency)", lat, exp_latency());
    extra_done = 0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk);
      #2;
      if (done) extra_done++;
    end
    check(extra_done == 0, "R8 no second done", extra_done, 0);
  endtask

  task automatic t_write_busy();
    int lat;
    int ready_seen;
    for (int i = 0; i < LANES; i++) vals[i] = WIDTH'(11 * i + 3);
    pack_par();
    @(negedge clk);
    start = 1'b1;
    load_par = 1'b1;
    wr_valid = 1'b1;
    wr_lane = '0;
    wr_data = 32'h4000_0000;
    #1;
    check(wr_ready == 1'b0, "R9 not ready with start high", longint'(wr_ready), 0);
    @(posedge clk);
    #1 start = 1'b0;
    lat = -1;
    ready_seen = 0;
    for (int n = 1; n <= 64; n++) begin
      @(posedge clk);
      #2;
      if (done) begin
        lat = n;
        wr_valid = 1'b0;
        break;
      end
      if (wr_ready) ready_seen++;
    end
    wr_valid = 1'b0;
    check(ready_seen == 0, "R9 ready low while busy", ready_seen, 0);
    check(sum_out == ref_sum(), "R9 write during run not taken", longint'(sum_out), longint'(ref_sum()));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_patterns();
    t_single_lanes();
    t_wrap();
    t_port();
    t_start_busy();
    t_write_busy();
    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule